// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns parallel words into asynchronous serial characters on a single transmit line. A one-word holding buffer accepts a word from the write port. When the shift stage is free, transmission is enabled and the clear-to-send gate allows it, the word moves into a frame shift register. It then leaves the line as a start bit, the data bits, an optional parity bit and one or two stop bits.

Each bit lasts sixteen ticks of an internal divider. The divider is restarted at the start of every character, so every bit is exactly `16*(divVal+1)` clock cycles long. The host chooses the character length, parity, stop count, bit order, data-only inversion and whole-line polarity through static configuration inputs. These are sampled when a character is loaded. An interrupt pulse marks either the hand-over from buffer to shift register or the end of the final stop bit.

Top module: `uart_tx_engine`

## Requirements
- R1: A frame is one start bit (logic 0) followed by the data bits. `charLen` 2'b00 selects 7 data bits, 2'b01 selects 8, and 2'b10 or 2'b11 select 9; only the low bits of `wrData` are used.
- R2: `parityMode` 2'b10 appends even parity and 2'b11 appends odd parity; 2'b00 and 2'b01 send no parity bit. Parity is taken over the data bits as they appear on the line, after data inversion. Even means the data bits plus the parity bit hold an even number of ones.
- R3: `twoStop`=0 sends one stop bit (logic 1) and `twoStop`=1 sends two.
- R4: Each bit, including the start bit, lasts 16*(divVal+1) clock cycles. The start bit appears on `txd` one clock after the start condition is met.
- R5: A character starts only when `txEnable`=1, the holding buffer is full, and either `ctsEnable`=0 or `ctsN`=0. While any of these is missing, `txd` stays idle and the word is kept.
- R6: `irq` is a one-cycle pulse. With `irqSelect`=0 it appears in the cycle in which the start bit first shows. With `irqSelect`=1 it appears in the first cycle after the last stop bit ends.
- R7: `msbFirst`=0 sends data bit 0 first; `msbFirst`=1 sends the highest data bit of the selected length first.
- R8: `dataInvert`=1 inverts only the data bits; start, parity rule and stop levels are unchanged.
- R9: `lineInvert`=1 inverts every level on `txd`, including idle, start and stop. The idle level is 1 when `lineInvert`=0.
- R10: `bufEmpty` is 1 after reset. A write clears it, and the move of the word into the shift register sets it. `busy` is 1 while a frame is on the line.
- R11: If a word is waiting when the last stop bit ends, the next start bit follows with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divVal | input | DIV_W | Tick divider value n (tick every n+1 clocks) |
| txEnable | input | 1 | Allows new characters to start |
| charLen | input | 2 | Data length select (7/8/9) |
| parityMode | input | 2 | Parity select (none/even/odd) |
| twoStop | input | 1 | Two stop bits when 1 |
| msbFirst | input | 1 | Send highest data bit first when 1 |
| dataInvert | input | 1 | Invert data bits only |
| lineInvert | input | 1 | Invert the whole line |
| irqSelect | input | 1 | 0: interrupt on load, 1: interrupt on completion |
| ctsEnable | input | 1 | Enables the clear-to-send gate |
| ctsN | input | 1 | Clear-to-send, active low |
| wrValid | input | 1 | Write strobe for the holding buffer |
| wrData | input | DATA_W | Word to send |
| txd | output | 1 | Serial line output |
| bufEmpty | output | 1 | Holding buffer empty flag |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench samples every bit in its middle for several character lengths, parity senses, stop counts and bit orders. This catches a design that counts parity before inversion, reverses the wrong number of bits, or flips start and stop bits with the data. It checks the exact cycle of the interrupt in both modes and of a back-to-back start. A divider or bit counter off by one would move those edges, and a hand-over that inserts an idle bit would delay the second start. It holds a written word behind a raised clear-to-send and behind a cleared enable, to expose a gate that leaks a frame or drops the word. Idle-level checks under whole-line inversion catch a polarity switch that is applied only inside frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // move holding word into frame register
    logic shift;  // advance frame register by one bit
  } txStrobe_t;

  typedef enum logic { ST_IDLE = 1'b0, ST_SHIFT = 1'b1 } txState_t;

  // Number of data bits for a length code
  function automatic logic [3:0] charBits(input logic [1:0] code);
    case (code)
      2'b00:   charBits = 4'd7;
      2'b01:   charBits = 4'd8;
      default: charBits = 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cnt == '0)) else $error("tick restart failed"); // R4
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_W    = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txEnable,
  input  logic       ctsEnable,
  input  logic       ctsN,
  input  logic       bufEmpty,
  input  logic [1:0] charLen,
  input  logic [1:0] parityMode,
  input  logic       twoStop,
  input  logic       irqSelect,
  output txStrobe_t  strobe,
  output logic       busy,
  output logic       irq
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int LEN_W = $clog2(FRAME_W + 1);

  txState_t         state;
  logic [SUB_W-1:0] subCnt;
  logic [LEN_W-1:0] bitCnt;
  logic [LEN_W-1:0] frameLen;
  logic [LEN_W-1:0] newLen;
  logic             ctsOk, canStart, bitEnd, lastBit, doneStb, loadStb;

  assign ctsOk    = !ctsEnable || !ctsN;
  assign canStart = txEnable && !bufEmpty && ctsOk;
  assign bitEnd   = (state == ST_SHIFT) && tick && (subCnt == SUB_W'(OVERSAMPLE - 1));
  assign lastBit  = (bitCnt == frameLen - LEN_W'(1));
  assign doneStb  = bitEnd && lastBit;
  assign loadStb  = canStart && ((state == ST_IDLE) || doneStb);

  // start + data + optional parity + stop bits
  assign newLen = LEN_W'(1) + LEN_W'(charBits(charLen)) + LEN_W'(parityMode[1])
                + (twoStop ? LEN_W'(2) : LEN_W'(1));

  assign strobe.load  = loadStb;
  assign strobe.shift = bitEnd;
  assign busy         = (state == ST_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      subCnt   <= '0;
      bitCnt   <= '0;
      frameLen <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= irqSelect ? doneStb : loadStb;
      if (loadStb) begin
        state    <= ST_SHIFT;
        subCnt   <= '0;
        bitCnt   <= '0;
        frameLen <= newLen;
      end else if (doneStb) begin
        state <= ST_IDLE;
      end else if (bitEnd) begin
        subCnt <= '0;
        bitCnt <= bitCnt + 1'b1;
      end else if (state == ST_SHIFT && tick) begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ctsEnable && ctsN) |=> (state == ST_IDLE)) else $error("start while CTS high"); // R5
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitCnt < frameLen)) else $error("bit counter overrun"); // R1
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq) else $error("irq longer than one cycle"); // R6
endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parityMode,
  input  logic              msbFirst,
  input  logic              dataInvert,
  output logic              bufEmpty,
  output logic              lineBit
);
  logic [DATA_W-1:0]  hold;
  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] newFrame;

  // Build the whole frame, first bit on the line at index 0
  always_comb begin
    int   nb;
    logic par;
    logic b;
    nb       = int'(charBits(charLen));
    par      = 1'b0;
    b        = 1'b0;
    newFrame = '1;
    newFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) begin
        b = msbFirst ? hold[nb - 1 - i] : hold[i];
        b = b ^ dataInvert;
        newFrame[1 + i] = b;
        par = par ^ b;
      end
    end
    if (parityMode[1]) newFrame[1 + nb] = parityMode[0] ? ~par : par;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hold     <= '0;
      bufEmpty <= 1'b1;
      frameReg <= '1;
    end else begin
      if (wrValid) begin
        hold     <= wrData;
        bufEmpty <= 1'b0;
      end else if (strobe.load) begin
        bufEmpty <= 1'b1;
      end
      if (strobe.load)       frameReg <= newFrame;
      else if (strobe.shift) frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign lineBit = frameReg[0];

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !bufEmpty) else $error("write did not clear empty"); // R10
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrValid) |=> bufEmpty) else $error("load did not set empty"); // R10
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !lineBit) else $error("start bit not low"); // R1
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 9,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              txEnable,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parityMode,
  input  logic              twoStop,
  input  logic              msbFirst,
  input  logic              dataInvert,
  input  logic              lineInvert,
  input  logic              irqSelect,
  input  logic              ctsEnable,
  input  logic              ctsN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              bufEmpty,
  output logic              busy,
  output logic              irq
);
  localparam int FRAME_W = DATA_W + 4;

  txStrobe_t strobe;
  logic      tick;
  logic      lineBit;

  uart_tx_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rstN(rstN), .divVal(divVal), .restart(strobe.load), .tick(tick)
  );

  uart_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .txEnable(txEnable),
    .ctsEnable(ctsEnable), .ctsN(ctsN), .bufEmpty(bufEmpty),
    .charLen(charLen), .parityMode(parityMode), .twoStop(twoStop),
    .irqSelect(irqSelect), .strobe(strobe), .busy(busy), .irq(irq)
  );

  uart_tx_dpath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrValid(wrValid), .wrData(wrData),
    .charLen(charLen), .parityMode(parityMode), .msbFirst(msbFirst),
    .dataInvert(dataInvert), .bufEmpty(bufEmpty), .lineBit(lineBit)
  );

  assign txd = lineBit ^ lineInvert;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (txd == !lineInvert)) else $error("idle level wrong"); // R9
endmodule

// File: tb/uart_tx_engine_tb_top.sv
module uart_tx_engine_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divVal = 8'd1;
  logic       txEnable = 1'b1;
  logic [1:0] charLen = 2'b01;
  logic [1:0] parityMode = 2'b00;
  logic       twoStop = 1'b0, msbFirst = 1'b0, dataInvert = 1'b0, lineInvert = 1'b0;
  logic       irqSelect = 1'b0, ctsEnable = 1'b0, ctsN = 1'b1;
  logic       wrValid = 1'b0;
  logic [8:0] wrData = '0;
  logic       txd, bufEmpty, busy, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uart_tx_engine dut_i (
    .clk(clk), .rstN(rstN), .divVal(divVal), .txEnable(txEnable), .charLen(charLen),
    .parityMode(parityMode), .twoStop(twoStop), .msbFirst(msbFirst),
    .dataInvert(dataInvert), .lineInvert(lineInvert), .irqSelect(irqSelect),
    .ctsEnable(ctsEnable), .ctsN(ctsN), .wrValid(wrValid), .wrData(wrData),
    .txd(txd), .bufEmpty(bufEmpty), .busy(busy), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Expected line levels from the requirements
  task automatic expFrame(input logic [8:0] d, output logic [12:0] bits, output int f);
    int n;
    logic p, b;
    n = (charLen == 2'b00) ? 7 : (charLen == 2'b01) ? 8 : 9;
    p = 1'b0;
    bits = '1;
    bits[0] = 1'b0;                                   // R1 start
    for (int j = 0; j < n; j++) begin
      b = msbFirst ? d[n-1-j] : d[j];                 // R7
      b = b ^ dataInvert;                             // R8
      bits[1+j] = b;
      p = p ^ b;
    end
    f = 1 + n;
    if (parityMode[1]) begin                          // R2
      bits[f] = parityMode[0] ? ~p : p;
      f++;
    end
    f += twoStop ? 2 : 1;                             // R3
    bits = bits ^ {13{lineInvert}};                   // R9
  endtask

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // Sends one frame (optionally writing it) and checks every bit and the irq
  task automatic runFrame(input logic [8:0] d, input bit doWrite, input string tag);
    logic [12:0] bits;
    int f, bt, waited, irqCnt, irqPos, expPos;
    expFrame(d, bits, f);
    bt = 16 * (int'(divVal) + 1);
    if (doWrite) begin
      writeWord(d);
      chk(bufEmpty == 1'b0, {"R10 empty cleared by write ", tag}, bufEmpty, 0);
    end
    waited = 0;
    while (txd !== bits[0] && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited == 1, {"R4 start latency ", tag}, waited, 1);
    irqCnt = 0; irqPos = -1;
    if (irq) begin irqCnt++; irqPos = 0; end
    for (int i = 1; i <= f * bt + 1; i++) begin
      @(negedge clk);
      if (irq) begin irqCnt++; if (irqPos < 0) irqPos = i; end
      if ((i % bt) == bt / 2 && (i / bt) < f)
        chk(txd == bits[i / bt], {"R1 frame bit ", tag}, txd, bits[i / bt]);
    end
    expPos = irqSelect ? f * bt : 0;
    chk(irqCnt == 1 && irqPos == expPos, {"R6 irq timing ", tag}, irqPos, expPos);
    chk(txd == !lineInvert && busy == 1'b0, {"R9 idle after frame ", tag}, txd, !lineInvert);
    chk(bufEmpty == 1'b1, {"R10 empty after load ", tag}, bufEmpty, 1);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk(txd == 1'b1 && bufEmpty == 1'b1 && busy == 1'b0 && irq == 1'b0,
        "R10 reset state", {txd, bufEmpty, busy, irq}, 4'b1100);
  endtask

  task automatic test8N1;
    divVal = 8'd1; charLen = 2'b01; parityMode = 2'b00; twoStop = 1'b0;
    msbFirst = 1'b0; irqSelect = 1'b0;
    runFrame(9'h0A5, 1'b1, "R1 8N1 lsb");
  endtask

  task automatic test7E2Msb;
    divVal = 8'd0; charLen = 2'b00; parityMode = 2'b10; twoStop = 1'b1;
    msbFirst = 1'b1; irqSelect = 1'b1;
    runFrame(9'h05B, 1'b1, "R2 R3 R7 7E2 msb");
  endtask

  task automatic test9OInv;
    divVal = 8'd3; charLen = 2'b10; parityMode = 2'b11; twoStop = 1'b0;
    msbFirst = 1'b0; dataInvert = 1'b1; irqSelect = 1'b1;
    runFrame(9'h1C6, 1'b1, "R8 R2 9O1 inverted");
    dataInvert = 1'b0;
  endtask

  task automatic testLineInv;
    divVal = 8'd1; charLen = 2'b01; parityMode = 2'b10; twoStop = 1'b1;
    irqSelect = 1'b0; lineInvert = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9 idle inverted", txd, 0);
    runFrame(9'h03C, 1'b1, "R9 line inverted");
    lineInvert = 1'b0;
    @(negedge clk);
  endtask

  task automatic testCts;
    divVal = 8'd0; charLen = 2'b01; parityMode = 2'b00; twoStop = 1'b0;
    ctsEnable = 1'b1; ctsN = 1'b1;
    writeWord(9'h081);
    repeat (300) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && bufEmpty == 1'b0, "R5 CTS holds frame",
        {txd, busy, bufEmpty}, 3'b100);
    ctsN = 1'b0;
    runFrame(9'h081, 1'b0, "R5 CTS released");
    ctsEnable = 1'b0; ctsN = 1'b1;
  endtask

  task automatic testEnable;
    divVal = 8'd0; txEnable = 1'b0;
    writeWord(9'h0F0);
    repeat (300) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && bufEmpty == 1'b0, "R5 disabled holds frame",
        {txd, busy, bufEmpty}, 3'b100);
    txEnable = 1'b1;
    irqSelect = 1'b1;
    runFrame(9'h0F0, 1'b0, "R5 enable released");
  endtask

  task automatic testBackToBack;
    logic [12:0] bitsB;
    int f, bt;
    divVal = 8'd0; charLen = 2'b01; parityMode = 2'b00; twoStop = 1'b0;
    msbFirst = 1'b0; irqSelect = 1'b0;
    bt = 16;
    expFrame(9'h0C3, bitsB, f);
    writeWord(9'h055);
    while (txd !== 1'b0) @(negedge clk);
    for (int i = 1; i <= 2 * f * bt + 4; i++) begin
      @(negedge clk);
      if (i == 1) chk(bufEmpty == 1'b1, "R10 empty on load", bufEmpty, 1);
      if (i == 2) begin wrValid = 1'b1; wrData = 9'h0C3; end
      if (i == 3) wrValid = 1'b0;
      if (i == f * bt - 1) chk(txd == 1'b1, "R11 stop before next", txd, 1);
      if (i == f * bt) begin
        chk(txd == 1'b0, "R11 no gap start", txd, 0);
        chk(irq == 1'b1, "R6 irq on second load", irq, 1);
      end
      if (i == f * bt + bt + bt / 2) chk(txd == bitsB[1], "R11 second frame data", txd, bitsB[1]);
    end
    chk(txd == 1'b1 && busy == 1'b0, "R11 idle after pair", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    test8N1();
    test7E2Msb();
    test9OInv();
    testLineInv();
    testCts();
    testEnable();
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule